// File: doc/BRIEF.md
# Tri-State Phase-Frequency Detector with Timed Overlap

This block compares the timing of two clock-like level inputs, a reference and a feedback signal, inside a fast system clock domain. It drives two pulse outputs for a charge pump. UP means the feedback lags and the oscillator should speed up. DN means the feedback leads and the oscillator should slow down. Each input level is synchronized, and its rising transitions are turned into single-cycle strobes. A strobe sets the flag that belongs to its input.

Once both flags are set, a timer keeps them asserted together for a fixed number of system cycles, then clears them in the same cycle. Because of this enforced overlap, even a zero phase error produces a short pulse on both outputs. That pulse removes the dead band of the comparator.

A signed two-bit code gives the net drive, UP minus DN. It is meant for digital loop models or for monitoring. All pins are plain control levels; there is no data stream, so no handshake is involved. The overlap length is derived from a clock period and a target overlap time, both given in picoseconds.

Top module: `phase_detect_top`

## Requirements
- R1: A synchronous active-high `rst` returns the block to idle on the next clock edge: `up_o`=0, `dn_o`=0, `err_o`=2'b00, timer cleared.
- R2: A rising transition on a level input, first sampled at clock edge n, acts on the flags at edge n+SYNC_STAGES. It produces exactly one strobe. A level that is held high produces no further action.
- R3: From idle, the state is encoded as {UP,DN}. A reference strobe alone gives up-only {1,0}. A feedback strobe alone gives down-only {0,1}. Both strobes in the same cycle give both {1,1}.
- R4: From up-only, a feedback strobe moves to both. From down-only, a reference strobe moves to both.
- R5: The overlap timer advances only while both flags are set and is zero otherwise. The both state therefore lasts exactly OVL_CYC = max(1, ceil(OVERLAP_PS/CLK_PERIOD_PS)) cycles, which is 2 with the defaults, on UP and DN alike.
- R6: When the overlap expires, UP and DN fall on the same edge and the block lands in idle.
- R7: A strobe on an input whose flag is already set has no effect.
- R8: A strobe that arrives in the cycle in which the overlap expires has no effect. A strobe one cycle later is accepted.
- R9: `err_o` is two's complement UP minus DN: 2'b01 in up-only, 2'b11 in down-only, 2'b00 in idle and in both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_lvl_i | input | 1 | Reference level, asynchronous to clk |
| fb_lvl_i | input | 1 | Feedback level, asynchronous to clk |
| up_o | output | 1 | Charge pump speed-up flag |
| dn_o | output | 1 | Charge pump slow-down flag |
| err_o | output | 2 | Signed net drive, UP minus DN |

## Verification
The hardest situation to produce from the ports is a new reference edge whose strobe lands exactly in the cycle in which the overlap timer expires. That edge must be dropped, while an edge one cycle later must be taken. The bench reaches it by pulsing the reference level low and raising it again at a time computed from the synchronizer latency and the overlap length. It then checks the outputs on every cycle around the expiry. A sweep of feedback-to-reference offsets on both sides of zero, including coincident edges, covers every path into the both state.

// File: rtl/phdet_pkg.sv
package phdet_pkg;

  // state encoding is {UP, DN}
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_DN   = 2'b01,
    ST_UP   = 2'b10,
    ST_BOTH = 2'b11
  } phdet_state_t;

  // signed net drive: UP minus DN in two's complement
  function automatic logic [1:0] net_drive(input phdet_state_t s);
    case (s)
      ST_UP:   return 2'b01;
      ST_DN:   return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  // overlap cycles from a clock period and a target overlap time
  function automatic int overlap_cycles(input int clk_ps, input int ovl_ps);
    int raw;
    raw = (ovl_ps + clk_ps - 1) / clk_ps;
    return (raw < 1) ? 1 : raw;
  endfunction

endpackage

// File: rtl/phdet_edge.sv
module phdet_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic strb
);

  logic [STAGES-1:0] sq;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sq <= '0;
        else     sq <= lvl;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sq <= '0;
        else     sq <= {sq[STAGES-2:0], lvl};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= sq[STAGES-1];
  end

  assign strb = sq[STAGES-1] & ~prev;

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    strb |=> !strb);

endmodule

// File: rtl/phdet_overlap_timer.sv
module phdet_overlap_timer #(
  parameter int OVL_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);

  localparam int TW = (OVL_CYC > 1) ? $clog2(OVL_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(OVL_CYC - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (run && !expire)  cnt <= cnt + 1'b1;
    else                      cnt <= '0;
  end

  assign expire = run && (cnt == LAST);

  // R5
  timer_starts_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> (cnt == '0));

  // R5
  timer_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));

endmodule

// File: rtl/phdet_flags.sv
module phdet_flags
  import phdet_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         ref_stb,
  input  logic         fb_stb,
  input  logic         expire,
  output phdet_state_t st
);

  phdet_state_t st_n;

  always_comb begin
    if (expire) st_n = ST_IDLE;
    else        st_n = phdet_state_t'({st[1] | ref_stb, st[0] | fb_stb});
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_n;
  end

  // R3
  idle_to_up_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && ref_stb && !fb_stb) |=> (st == ST_UP));

  // R3
  idle_to_dn_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && fb_stb && !ref_stb) |=> (st == ST_DN));

  // R4
  up_to_both_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_UP && fb_stb) |=> (st == ST_BOTH));

  // R4
  dn_to_both_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DN && ref_stb) |=> (st == ST_BOTH));

  // R6
  expire_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> (st == ST_IDLE));

  // R6
  both_leaves_on_expire_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BOTH && !expire) |=> (st == ST_BOTH));

  // R7
  up_held_chk: assert property (@(posedge clk) disable iff (rst)
    (st[1] && !expire) |=> st[1]);

  // R7
  dn_held_chk: assert property (@(posedge clk) disable iff (rst)
    (st[0] && !expire) |=> st[0]);

endmodule

// File: rtl/phase_detect_top.sv
module phase_detect_top
  import phdet_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int CLK_PERIOD_PS = 8000,
  parameter int OVERLAP_PS    = 10000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_lvl_i,
  input  logic       fb_lvl_i,
  output logic       up_o,
  output logic       dn_o,
  output logic [1:0] err_o
);

  localparam int OVL_CYC = overlap_cycles(CLK_PERIOD_PS, OVERLAP_PS);
  localparam int NIN     = 2;

  logic [NIN-1:0] lvl;
  logic [NIN-1:0] stb;
  logic           expire;
  phdet_state_t   st;

  assign lvl = {fb_lvl_i, ref_lvl_i};

  generate
    for (genvar g = 0; g < NIN; g++) begin : g_in
      phdet_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl[g]),
        .strb (stb[g])
      );
    end
  endgenerate

  phdet_overlap_timer #(.OVL_CYC(OVL_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (st == ST_BOTH),
    .expire (expire)
  );

  phdet_flags u_flags (
    .clk     (clk),
    .rst     (rst),
    .ref_stb (stb[0]),
    .fb_stb  (stb[1]),
    .expire  (expire),
    .st      (st)
  );

  assign up_o  = st[1];
  assign dn_o  = st[0];
  assign err_o = net_drive(st);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!up_o && !dn_o));

  // R6
  joint_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(up_o) |-> $fell(dn_o));

endmodule

// File: tb/phase_detect_top_bench.sv
module phase_detect_top_bench;

  localparam int CLK_PS = 8000;
  localparam int OVL_PS = 10000;
  localparam int D      = (OVL_PS + CLK_PS - 1) / CLK_PS;
  localparam int NEVER  = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_lvl = 1'b0;
  logic       fb_lvl = 1'b0;
  logic       up_o, dn_o;
  logic [1:0] err_o;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #4ns clk = ~clk;

  phase_detect_top #(
    .SYNC_STAGES   (2),
    .CLK_PERIOD_PS (CLK_PS),
    .OVERLAP_PS    (OVL_PS)
  ) u_phase_detect_top (
    .clk       (clk),
    .rst       (rst),
    .ref_lvl_i (ref_lvl),
    .fb_lvl_i  (fb_lvl),
    .up_o      (up_o),
    .dn_o      (dn_o),
    .err_o     (err_o)
  );

  task automatic chk(input string tag, input int k, input logic eu, input logic ed);
    logic [1:0] ee;
    ee = (eu && !ed) ? 2'b01 : ((ed && !eu) ? 2'b11 : 2'b00);
    n_cmp++;
    if ({up_o, dn_o, err_o} !== {eu, ed, ee}) begin
      n_bad++;
      $display("FAIL %s edge %0d: got up=%b dn=%b err=%b expected up=%b dn=%b err=%b",
               tag, k, up_o, dn_o, err_o, eu, ed, ee);
    end
  endtask

  // R1: reset clears everything on the next edge
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ref_lvl = 1'b0; fb_lvl = 1'b0;
    @(negedge clk);
    chk("R1 reset", 0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // edge i is the i-th rising clock edge after the start; levels set before it
  task automatic run_case(input string tag, input int r1, input int rf, input int r2,
                          input int f1, input int us, input int ue, input int u2s,
                          input int u2e, input int ds, input int de, input int n);
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      if (i > 0) begin
        int k;
        k = i - 1;
        chk(tag, k, ((k >= us) && (k < ue)) || ((k >= u2s) && (k < u2e)),
            (k >= ds) && (k < de));
      end
      ref_lvl = ((i >= r1) && (i < rf)) || (i >= r2);
      fb_lvl  = (i >= f1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    do_reset();

    // R2 R3 R9: reference alone, held high, gives up-only forever
    run_case("R2/R3/R9 ref only", 3, NEVER, NEVER, NEVER, 5, NEVER, NEVER, NEVER,
             NEVER, NEVER, 16);
    do_reset();  // R1 from a non-idle state

    // R2 R3 R9: feedback alone gives down-only
    run_case("R2/R3/R9 fb only", NEVER, NEVER, NEVER, 3, NEVER, NEVER, NEVER, NEVER,
             5, NEVER, 16);
    do_reset();

    // R3 R4 R5 R6 R9: offset sweep, coincident edges included
    for (int d = -6; d <= 6; d++) begin
      int ra, fa, m;
      ra = 8;
      fa = 8 + d;
      m  = (ra > fa) ? ra : fa;
      run_case("R3/R4/R5/R6/R9 sweep", ra, NEVER, NEVER, fa, ra + 2, m + 2 + D,
               NEVER, NEVER, fa + 2, m + 2 + D, 26 + D);
      do_reset();
    end

    // R7: second reference rise while up is set has no effect
    run_case("R7 repeat ref", 3, 4, 6, 12, 5, 14 + D, NEVER, NEVER, 14, 14 + D, 22 + D);
    do_reset();

    // R8: reference strobe in the expiry cycle is dropped
    if (D >= 2) begin
      run_case("R8 edge at expiry", 3, 4, 3 + D, 3, 5, 5 + D, NEVER, NEVER,
               5, 5 + D, 16 + D);
      do_reset();
    end

    // R8: one cycle later the strobe is taken
    run_case("R8 edge after expiry", 3, 4, 4 + D, 3, 5, 5 + D, 6 + D, NEVER,
             5, 5 + D, 16 + D);
    do_reset();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule